// File: doc/BRIEF.md
# Multiplexed-Bus Burst Write Timing Generator

This block drives one synchronous burst write of eight words to an external memory. The memory shares a single 16-bit bus between address and data. The low address half goes out on that bus first. The upper address bits go out on dedicated lines for the whole access. Every control edge, the clock start, the first data beat and the beat spacing are each placed by their own cycle count, measured in functional-clock cycles from the start of the access. Each chip select therefore gets its own timing profile.

A request is accepted only while the generator is idle. From then on a single access timer steps once per functional cycle. The chip select, address-valid and write-enable strobes are derived from that timer, and so are the bus contents and the external clock. The device can hold off the data beats with a wait input. When the programmed cycle time is reached, a one-cycle done pulse marks the end of the access. The bus direction output keeps driving for one further cycle and then turns back to input.

Top module: `mux_burst_wr_gen`

## Requirements
- R1: After reset and while idle: cs_n_o, adv_n_o and we_n_o are 1; be_n_o is all ones; dir_o, done_o and mclk_o are 0; ad_o and a_hi_o are 0.
- R2: A start_i seen at a clock edge while idle begins an access. Access cycle t = 0 is the cycle after that edge, and t rises by one every cycle after that. A start_i raised during an access has no effect on that access.
- R3: cs_n_o is 0 exactly in access cycles with cs_on_i <= t < cs_off_i. If the two times are equal, chip select never asserts.
- R4: adv_n_o is 0 exactly in access cycles with adv_on_i <= t < adv_off_i.
- R5: we_n_o is 0 exactly in access cycles with we_on_i <= t < we_off_i.
- R6: In access cycles with t < dat_on_i, ad_o carries addr_i[15:0] and be_n_o is all ones. Throughout the access, a_hi_o carries addr_i[AW-1:16].
- R7: From t = dat_on_i, beat k (k = 0..7) drives data_i[16k+15:16k] on ad_o and ~be_i[2k+1:2k] on be_n_o. Each beat lasts page_i cycles; a page_i of 0 counts as 1. Beat 7 stays on the bus until the access ends.
- R8: Each data-phase cycle in which wait_i is 1 lengthens the current beat by one cycle. The access timer keeps counting during those cycles.
- R9: With clk_div_i = 0 the external clock has a period of 2 cycles; with clk_div_i = 1 the period is 4 cycles. For t >= clk_act_i, mclk_o = ((t - clk_act_i) / d) mod 2, where d is 1 or 2 respectively. Otherwise mclk_o is 0.
- R10: done_o is 1 for exactly the one cycle with t = cycle_i, and the access ends after it. A start_i in the next cycle is accepted.
- R11: dir_o is 1 from t = 0 through the cycle after done_o, then 0 unless a new access has begun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | functional clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| start_i | input | 1 | access request |
| wait_i | input | 1 | device hold-off, stalls the data beats |
| addr_i | input | AW | write start address |
| data_i | input | 8*16 | eight data words, word k at bits 16k+15:16k |
| be_i | input | 8*2 | active-high byte enables, two per word |
| cs_on_i | input | TW | chip-select assert cycle |
| cs_off_i | input | TW | chip-select release cycle |
| adv_on_i | input | TW | address-valid assert cycle |
| adv_off_i | input | TW | address-valid release cycle |
| we_on_i | input | TW | write-enable assert cycle |
| we_off_i | input | TW | write-enable release cycle |
| dat_on_i | input | TW | cycle of the first data beat |
| page_i | input | TW | cycles per data beat |
| clk_act_i | input | TW | external clock activation cycle |
| cycle_i | input | TW | total write cycle time |
| clk_div_i | input | 1 | external clock divide, 0 = 1, 1 = 2 |
| mclk_o | output | 1 | external clock |
| cs_n_o | output | 1 | chip select, active low |
| adv_n_o | output | 1 | address valid, active low |
| we_n_o | output | 1 | write enable, active low |
| be_n_o | output | 2 | byte enables, active low |
| dir_o | output | 1 | bus direction, 1 = drive |
| ad_o | output | 16 | multiplexed address/data bus |
| a_hi_o | output | AW-16 | upper address lines |
| done_o | output | 1 | access end pulse |

## Verification
Two things can fall on the same cycle. A wait hold-off can land exactly on a beat boundary. A fresh request can land in the cycle where the generator has just gone idle while direction is still held. The bench raises wait_i on the last cycle of a beat and checks that the beat is stretched by exactly the number of wait cycles. It also raises start_i in the cycle after done_o, expects dir_o to stay 1 without a gap, and expects the second access to begin at t = 0 with its own profile. A request placed in the middle of an access is also sent. The bench checks that every strobe and data edge still follows the first timer.

// File: rtl/mbw_pkg.sv
package mbw_pkg;
  typedef enum logic {
    DIV_1 = 1'b0,
    DIV_2 = 1'b1
  } ck_div_e;

  localparam int NSTB = 3;  // cs, adv, we
endpackage

// File: rtl/mbw_seq.sv
module mbw_seq #(
  parameter int TW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [TW-1:0] cycle_i,
  output logic          acc_o,
  output logic          act_o,
  output logic [TW-1:0] t_o,
  output logic          done_o,
  output logic          dir_o
);
  logic          act_q, hold_q;
  logic [TW-1:0] t_q;

  assign acc_o  = start_i && !act_q;
  assign done_o = act_q && (t_q == cycle_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      t_q    <= '0;
      hold_q <= 1'b0;
    end else begin
      hold_q <= done_o;
      if (acc_o) begin
        act_q <= 1'b1;
        t_q   <= '0;
      end else if (done_o) begin
        act_q <= 1'b0;
      end else if (act_q) begin
        t_q <= t_q + 1'b1;
      end
    end
  end

  assign act_o = act_q;
  assign t_o   = t_q;
  assign dir_o = act_q | hold_q;
endmodule

// File: rtl/mbw_window.sv
module mbw_window #(
  parameter int TW = 6
) (
  input  logic          act_i,
  input  logic [TW-1:0] t_i,
  input  logic [TW-1:0] on_i,
  input  logic [TW-1:0] off_i,
  output logic          asrt_o
);
  assign asrt_o = act_i && (t_i >= on_i) && (t_i < off_i);
endmodule

// File: rtl/mbw_beats.sv
module mbw_beats #(
  parameter int AW    = 26,
  parameter int DW    = 16,
  parameter int BEATS = 8,
  parameter int TW    = 6,
  localparam int BB   = DW / 8,
  localparam int BIW  = $clog2(BEATS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                acc_i,
  input  logic                act_i,
  input  logic [TW-1:0]       t_i,
  input  logic [TW-1:0]       dat_on_i,
  input  logic [TW-1:0]       page_i,
  input  logic                wait_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [BEATS*DW-1:0] data_i,
  input  logic [BEATS*BB-1:0] be_i,
  output logic                ph_o,
  output logic [DW-1:0]       ad_o,
  output logic [BB-1:0]       be_n_o,
  output logic [AW-DW-1:0]    a_hi_o
);
  logic [BIW-1:0] b_q;
  logic [TW-1:0]  p_q;
  logic [TW:0]    p_nx;

  assign ph_o = act_i && (t_i >= dat_on_i);
  assign p_nx = {1'b0, p_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_q <= '0;
      p_q <= '0;
    end else if (acc_i) begin
      b_q <= '0;
      p_q <= '0;
    end else if (ph_o && !wait_i) begin
      if (p_nx >= {1'b0, page_i}) begin
        p_q <= '0;
        if (b_q != BIW'(BEATS - 1)) b_q <= b_q + 1'b1;
      end else begin
        p_q <= p_nx[TW-1:0];
      end
    end
  end

  always_comb begin
    ad_o   = '0;
    be_n_o = '1;
    if (ph_o) begin
      ad_o   = data_i[int'(b_q)*DW +: DW];
      be_n_o = ~be_i[int'(b_q)*BB +: BB];
    end else if (act_i) begin
      ad_o = addr_i[DW-1:0];
    end
  end

  assign a_hi_o = act_i ? addr_i[AW-1:DW] : '0;
endmodule

// File: rtl/mbw_mclk.sv
module mbw_mclk #(
  parameter int TW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic [TW-1:0] t_i,
  input  logic [TW-1:0] clk_act_i,
  input  logic          div_i,
  output logic          mclk_o
);
  import mbw_pkg::*;
  ck_div_e div;
  logic    run, ck_q, dc_q;

  assign div = ck_div_e'(div_i);
  assign run = act_i && (t_i >= clk_act_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_q <= 1'b0;
      dc_q <= 1'b0;
    end else if (!run) begin
      ck_q <= 1'b0;
      dc_q <= 1'b0;
    end else if (div == DIV_1 || dc_q) begin
      ck_q <= ~ck_q;
      dc_q <= 1'b0;
    end else begin
      dc_q <= 1'b1;
    end
  end

  // gate so the clock parks low as soon as the access ends
  assign mclk_o = ck_q & run;
endmodule

// File: rtl/mux_burst_wr_gen.sv
module mux_burst_wr_gen #(
  parameter int AW    = 26,
  parameter int DW    = 16,
  parameter int BEATS = 8,
  parameter int TW    = 6,
  localparam int BB   = DW / 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                wait_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [BEATS*DW-1:0] data_i,
  input  logic [BEATS*BB-1:0] be_i,
  input  logic [TW-1:0]       cs_on_i,
  input  logic [TW-1:0]       cs_off_i,
  input  logic [TW-1:0]       adv_on_i,
  input  logic [TW-1:0]       adv_off_i,
  input  logic [TW-1:0]       we_on_i,
  input  logic [TW-1:0]       we_off_i,
  input  logic [TW-1:0]       dat_on_i,
  input  logic [TW-1:0]       page_i,
  input  logic [TW-1:0]       clk_act_i,
  input  logic [TW-1:0]       cycle_i,
  input  logic                clk_div_i,
  output logic                mclk_o,
  output logic                cs_n_o,
  output logic                adv_n_o,
  output logic                we_n_o,
  output logic [BB-1:0]       be_n_o,
  output logic                dir_o,
  output logic [DW-1:0]       ad_o,
  output logic [AW-DW-1:0]    a_hi_o,
  output logic                done_o
);
  import mbw_pkg::*;

  logic                     acc, act, ph;
  logic [TW-1:0]            t_cnt;
  logic [NSTB-1:0][TW-1:0]  stb_on, stb_off;
  logic [NSTB-1:0]          stb;

  mbw_seq #(.TW(TW)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .cycle_i(cycle_i),
    .acc_o  (acc),
    .act_o  (act),
    .t_o    (t_cnt),
    .done_o (done_o),
    .dir_o  (dir_o)
  );

  assign stb_on  = {we_on_i,  adv_on_i,  cs_on_i};
  assign stb_off = {we_off_i, adv_off_i, cs_off_i};

  for (genvar g = 0; g < NSTB; g++) begin : g_stb
    mbw_window #(.TW(TW)) u_win (
      .act_i (act),
      .t_i   (t_cnt),
      .on_i  (stb_on[g]),
      .off_i (stb_off[g]),
      .asrt_o(stb[g])
    );
  end

  assign cs_n_o  = ~stb[0];
  assign adv_n_o = ~stb[1];
  assign we_n_o  = ~stb[2];

  mbw_beats #(.AW(AW), .DW(DW), .BEATS(BEATS), .TW(TW)) u_beats (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (acc),
    .act_i   (act),
    .t_i     (t_cnt),
    .dat_on_i(dat_on_i),
    .page_i  (page_i),
    .wait_i  (wait_i),
    .addr_i  (addr_i),
    .data_i  (data_i),
    .be_i    (be_i),
    .ph_o    (ph),
    .ad_o    (ad_o),
    .be_n_o  (be_n_o),
    .a_hi_o  (a_hi_o)
  );

  mbw_mclk #(.TW(TW)) u_mclk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .act_i    (act),
    .t_i      (t_cnt),
    .clk_act_i(clk_act_i),
    .div_i    (clk_div_i),
    .mclk_o   (mclk_o)
  );
endmodule

// File: rtl/mbw_chk.sv
module mbw_chk #(
  parameter int TW = 6,
  parameter int DW = 16,
  parameter int BB = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          wait_i,
  input logic          act_i,
  input logic [TW-1:0] t_i,
  input logic          ph_i,
  input logic [TW-1:0] cka_i,
  input logic          done_i,
  input logic          dir_i,
  input logic          cs_n_i,
  input logic [DW-1:0] ad_i,
  input logic [BB-1:0] be_n_i,
  input logic          mclk_i
);
  p_start_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_i && start_i) |=> (act_i && t_i == '0));

  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && start_i && !done_i) |=> (t_i == $past(t_i) + 1'b1));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (!done_i && !act_i));

  p_dir_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> dir_i);

  p_cs_drive_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_i |-> dir_i);

  p_wait_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_i && wait_i && !done_i) |=> ($stable(ad_i) && $stable(be_n_i)));

  p_clk_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_i || t_i < cka_i) |-> !mclk_i);
endmodule

bind mux_burst_wr_gen mbw_chk #(.TW(TW), .DW(DW), .BB(BB)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .wait_i (wait_i),
  .act_i  (act),
  .t_i    (t_cnt),
  .ph_i   (ph),
  .cka_i  (clk_act_i),
  .done_i (done_o),
  .dir_i  (dir_o),
  .cs_n_i (cs_n_o),
  .ad_i   (ad_o),
  .be_n_i (be_n_o),
  .mclk_i (mclk_o)
);

// File: tb/mux_burst_wr_gen_bench.sv
`timescale 1ns/1ps
module mux_burst_wr_gen_bench;
  localparam int AW = 26, DW = 16, BEATS = 8, TW = 6, BB = 2;

  logic                clk = 1'b0, rst_ni = 1'b0, start = 1'b0, wt = 1'b0;
  logic [AW-1:0]       addr;
  logic [BEATS*DW-1:0] data;
  logic [BEATS*BB-1:0] be;
  logic [TW-1:0]       cso, cse, ado, ade, weo, wee, dao, pg, cka, cyc;
  logic                div;
  logic                mclk, cs_n, adv_n, we_n, dir, done;
  logic [BB-1:0]       be_n;
  logic [DW-1:0]       ad;
  logic [AW-DW-1:0]    a_hi;

  int n_run = 0, n_fail = 0, cyc_cnt = 0;

  always #5 clk = ~clk;

  mux_burst_wr_gen #(.AW(AW), .DW(DW), .BEATS(BEATS), .TW(TW)) u_mux_burst_wr_gen (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .wait_i(wt),
    .addr_i(addr), .data_i(data), .be_i(be),
    .cs_on_i(cso), .cs_off_i(cse), .adv_on_i(ado), .adv_off_i(ade),
    .we_on_i(weo), .we_off_i(wee), .dat_on_i(dao), .page_i(pg),
    .clk_act_i(cka), .cycle_i(cyc), .clk_div_i(div),
    .mclk_o(mclk), .cs_n_o(cs_n), .adv_n_o(adv_n), .we_n_o(we_n),
    .be_n_o(be_n), .dir_o(dir), .ad_o(ad), .a_hi_o(a_hi), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_prof(input int a, b, c, d, e, f, g, h, k, y, input bit dv);
    cso = TW'(a); cse = TW'(b); ado = TW'(c); ade = TW'(d);
    weo = TW'(e); wee = TW'(f); dao = TW'(g); pg = TW'(h);
    cka = TW'(k); cyc = TW'(y); div = dv;
  endtask

  task automatic fill(input int seed);
    addr = AW'(32'h2A5_1234 + seed * 32'h111);
    for (int i = 0; i < BEATS; i++) begin
      data[i*DW +: DW] = DW'(16'hD000 + seed * 16'h100 + i);
      be[i*BB +: BB]   = BB'(i + seed);
    end
  endtask

  // wait raised for wn cycles from cycle wa; stray start at cycle gl; chain: start at cyc+1
  task automatic run_burst(input int wa, input int wn, input int gl, input bit chain, input bit started);
    int b = 0, p = 0, last, dvv;
    bit w;
    string rq;
    last = chain ? int'(cyc) + 1 : int'(cyc) + 2;
    dvv = div ? 2 : 1;
    if (!started) begin
      @(negedge clk); start = 1'b1;
    end
    @(negedge clk); start = 1'b0;
    for (int t = 0; t <= last; t++) begin
      bit on = (t <= int'(cyc));
      w = (t >= wa) && (t < wa + wn);
      wt = w;
      start = (t == gl);
      chk(cs_n  == !(on && t >= int'(cso) && t < int'(cse)), "R3 cs_n", cs_n, !(on && t >= int'(cso) && t < int'(cse)));
      chk(adv_n == !(on && t >= int'(ado) && t < int'(ade)), "R4 adv_n", adv_n, !(on && t >= int'(ado) && t < int'(ade)));
      chk(we_n  == !(on && t >= int'(weo) && t < int'(wee)), "R5 we_n", we_n, !(on && t >= int'(weo) && t < int'(wee)));
      chk(a_hi == (on ? addr[AW-1:DW] : '0), "R6 a_hi", a_hi, on ? addr[AW-1:DW] : 0);
      if (!on) begin
        chk(ad == '0 && be_n == '1, "R1 idle bus", {be_n, ad}, {2'b11, 16'h0});
      end else if (t < int'(dao)) begin
        chk(ad == addr[DW-1:0] && be_n == '1, "R6 address phase", {be_n, ad}, {2'b11, addr[DW-1:0]});
      end else begin
        rq = (wn > 0) ? "R8 beat with wait" : "R7 beat";
        chk(ad == data[b*DW +: DW] && be_n == ~be[b*BB +: BB], rq, {be_n, ad}, {~be[b*BB +: BB], data[b*DW +: DW]});
      end
      begin
        bit em = on && t >= int'(cka) && (((t - int'(cka)) / dvv) % 2 == 1);
        chk(mclk == em, "R9 mclk", mclk, em);
      end
      chk(done == (t == int'(cyc)), "R10 done", done, t == int'(cyc));
      chk(dir == (t <= int'(cyc) + 1), "R11 dir", dir, t <= int'(cyc) + 1);
      if (gl >= 0 && t == gl + 1) chk(dir && !done, "R2 start ignored while busy", {dir, done}, 2'b10);
      if (on && t >= int'(dao) && !w) begin
        if (p + 1 >= int'(pg)) begin p = 0; if (b < BEATS - 1) b++; end
        else p++;
      end
      if (chain && t == last) begin
        start = 1'b1;
        wt = 1'b0;
        return;
      end
      @(negedge clk);
    end
    wt = 1'b0;
    start = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(cs_n && adv_n && we_n && be_n == '1, "R1 strobes idle", {cs_n, adv_n, we_n, be_n}, 5'h1f);
    chk(!dir && !done && !mclk, "R1 dir/done/mclk idle", {dir, done, mclk}, 0);
    chk(ad == '0 && a_hi == '0, "R1 bus idle", {a_hi, ad}, 0);
  endtask

  task automatic t_basic;
    fill(1);
    set_prof(0, 23, 1, 3, 4, 21, 4, 2, 2, 24, 1'b0);
    run_burst(-1, 0, -1, 1'b0, 1'b0);
  endtask

  task automatic t_wait_div2;
    fill(2);
    // adv on == off: never asserts; wait straddles the end of beat 1 (pg=2 -> beat1 at t 5..6)
    set_prof(1, 18, 2, 2, 3, 17, 3, 2, 0, 22, 1'b1);
    run_burst(6, 3, -1, 1'b0, 1'b0);
  endtask

  task automatic t_stray_start;
    fill(3);
    // beat 7 ends at t=28 naturally and is held to t=34
    set_prof(2, 33, 0, 4, 5, 30, 5, 3, 5, 34, 1'b0);
    run_burst(-1, 0, 6, 1'b0, 1'b0);
  endtask

  task automatic t_chain;
    fill(4);
    set_prof(0, 12, 0, 2, 2, 11, 2, 1, 1, 12, 1'b1);
    run_burst(-1, 0, -1, 1'b1, 1'b0);
    fill(5);
    set_prof(1, 14, 0, 1, 3, 13, 3, 0, 0, 14, 1'b0);
    chk(dir == 1'b1, "R11 dir held into chained access", dir, 1);
    run_burst(4, 1, -1, 1'b0, 1'b1);
  endtask

  initial begin
    set_prof(0, 0, 0, 0, 0, 0, 0, 1, 0, 4, 1'b0);
    fill(0);
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    t_reset;
    t_basic;
    t_wait_div2;
    t_stray_start;
    t_chain;
    repeat (3) @(negedge clk);
    t_reset;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc_cnt, 20000);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule